// File: doc/BRIEF.md
# Chunked SPI Flash Read Sequencer

This block copies a run of bytes of any length from a serial NOR flash into a byte-wide memory write port. A request gives a 24-bit flash start address, a destination address and a byte count, and is launched by a one-cycle start strobe. The sequencer splits the request into pieces that fit a 64-entry receive FIFO. For each piece it runs one burst on the SPI pins: the plain read command, then the address, then dummy bytes while the flash streams data back.

The receive FIFO captures every byte on the MISO line, including the four bytes that arrive while the command header is still going out. The sequencer drops those four bytes and writes only the payload to memory, at consecutive addresses. Between two bursts it holds chip select high for a configurable deselect time, which defaults to 1 µs at a 100 MHz clock. This also holds between the last burst of one request and the first burst of the next. At the end of a request it pulses `done` for one cycle.

Top module: `spi_chunk_reader`

## Requirements
- R1: Every burst starts with command byte 0x03, then the 24-bit flash address with the most significant byte first, shifted on `spi_mosi` in SPI mode 0 (data set while `spi_sclk` is low, sampled on its rising edge, most significant bit first).
- R2: A burst carries at most FIFO_DEPTH−4 payload bytes (60 by default). Every burst of a request carries that maximum except the last, which carries the remainder. The receive FIFO is never pushed while full.
- R3: Chip select stays low for exactly 8·(4+n) rising edges of `spi_sclk`, where n is the payload length of the burst. `spi_sclk` is low whenever `spi_cs_n` is high.
- R4: The four bytes received during the header are never written. Payload byte i of a burst is written to the destination address of that burst plus i, with the value read from flash address plus i. Writes within a burst occur on consecutive cycles at increasing addresses.
- R5: After each burst the flash address and the destination address both advance by the burst length, and the remaining count drops by that length. The bytes of a request therefore form one contiguous copy.
- R6: Between any two bursts, within one request or across back-to-back requests, `spi_cs_n` stays high for at least GAP_CYCLES clock cycles.
- R7: A start with a byte count of zero raises `done` in the cycle after the strobe is sampled. It causes no chip-select activity and no memory write.
- R8: `busy` rises in the cycle after an accepted start and stays high until `done`. `done` is high for exactly one cycle, after the last memory write of the request.
- R9: A start strobe that arrives while `busy` is high is ignored. It causes no extra burst and no extra write.
- R10: During reset `spi_cs_n` is 1, and `spi_sclk`, `mem_we`, `done` and `busy` are 0.
- R11: The FIFO is drained only after all 4+n bytes of a burst have arrived, so `mem_we` is never high while `spi_cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe, taken only when idle |
| src_addr | input | 24 | Flash start address |
| dst_addr | input | DEST_W | First destination address |
| byte_len | input | LEN_W | Number of bytes to copy |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_we | output | 1 | Memory byte write enable |
| mem_addr | output | DEST_W | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The hardest case to reach from the ports is the deselect gap measured across a request boundary. It appears only when a new start follows the completion pulse at once, so the second request's first burst comes right after the previous request's last burst. The bench issues such a back-to-back pair. It also issues a request whose second burst address carries across a byte boundary of the 24-bit address (0x00FFE0 plus 60), so that a wrong address step shows up in the header. A start strobe is fired in the middle of a three-burst copy to show that it is ignored.

// File: rtl/spi_chunk_pkg.sv
package spi_chunk_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LOAD,
    SQ_WAIT,
    SQ_SKIP,
    SQ_DRAIN,
    SQ_GAP,
    SQ_FINISH
  } seq_state_t;

  typedef enum logic [0:0] {
    BE_IDLE,
    BE_SHIFT
  } burst_state_t;

  localparam logic [7:0] OPC_SLOW_READ = 8'h03;
  localparam int         HDR_BYTES     = 4;

  // Length of the next piece: the remainder, clipped to the cap.
  function automatic logic [31:0] chunk_take(input logic [31:0] remain,
                                             input logic [31:0] cap);
    return (remain > cap) ? cap : remain;
  endfunction

  // Command word shifted out first: opcode then 24-bit address.
  function automatic logic [31:0] read_header(input logic [23:0] addr);
    return {OPC_SLOW_READ, addr};
  endfunction

endpackage

// File: rtl/spi_burst_engine.sv
module spi_burst_engine
  import spi_chunk_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int CNT_W    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] total,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [31:0]      header,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso,
  output logic             rx_push,
  output logic [7:0]       rx_byte,
  output logic             burst_end
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  burst_state_t     st;
  logic [DIV_W-1:0] div_cnt;
  logic [2:0]       bit_cnt;
  logic [CNT_W-1:0] byte_cnt;
  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] tx_q;
  logic [31:0]      hdr_sh;
  logic [7:0]       tx_sh;
  logic [7:0]       rx_sh;
  logic             half_tick;
  logic             ev_rise;
  logic             ev_fall;
  logic [CNT_W-1:0] next_idx;
  logic             last_byte;

  generate
    if (HALF_DIV > 1) begin : g_div
      assign half_tick = (div_cnt == DIV_W'(HALF_DIV - 1));
    end else begin : g_nodiv
      assign half_tick = 1'b1;
    end
  endgenerate

  assign ev_rise   = (st == BE_SHIFT) && half_tick && !sclk;
  assign ev_fall   = (st == BE_SHIFT) && half_tick && sclk;
  assign next_idx  = byte_cnt + 1'b1;
  assign last_byte = (next_idx == total_q);
  assign mosi      = tx_sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= BE_IDLE;
      div_cnt   <= '0;
      bit_cnt   <= '0;
      byte_cnt  <= '0;
      total_q   <= '0;
      tx_q      <= '0;
      hdr_sh    <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      sclk      <= 1'b0;
      cs_n      <= 1'b1;
      rx_push   <= 1'b0;
      rx_byte   <= '0;
      burst_end <= 1'b0;
    end else begin
      rx_push   <= 1'b0;
      burst_end <= 1'b0;
      unique case (st)
        BE_IDLE: begin
          if (go) begin
            st       <= BE_SHIFT;
            cs_n     <= 1'b0;
            sclk     <= 1'b0;
            div_cnt  <= '0;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            total_q  <= total;
            tx_q     <= tx_cnt;
            hdr_sh   <= {header[23:0], 8'h00};
            tx_sh    <= (tx_cnt != '0) ? header[31:24] : 8'h00;
          end
        end
        BE_SHIFT: begin
          div_cnt <= half_tick ? '0 : div_cnt + 1'b1;
          if (ev_rise) begin
            sclk  <= 1'b1;
            rx_sh <= {rx_sh[6:0], miso};
          end
          if (ev_fall) begin
            sclk <= 1'b0;
            if (bit_cnt == 3'd7) begin
              rx_push  <= 1'b1;
              rx_byte  <= rx_sh;
              bit_cnt  <= '0;
              byte_cnt <= next_idx;
              if (last_byte) begin
                st        <= BE_IDLE;
                cs_n      <= 1'b1;
                burst_end <= 1'b1;
                tx_sh     <= 8'h00;
              end else begin
                tx_sh  <= (next_idx < tx_q) ? hdr_sh[31:24] : 8'h00;
                hdr_sh <= {hdr_sh[23:0], 8'h00};
              end
            end else begin
              tx_sh   <= {tx_sh[6:0], 1'b0};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        default: st <= BE_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_rx_fifo.sv
module spi_rx_fifo #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [7:0]       din,
  input  logic             pop,
  output logic [7:0]       dout,
  output logic [CNT_W-1:0] count
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  assign dout = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/spi_chunk_reader.sv
module spi_chunk_reader
  import spi_chunk_pkg::*;
#(
  parameter int DEST_W     = 16,
  parameter int LEN_W      = 16,
  parameter int FIFO_DEPTH = 64,
  parameter int HALF_DIV   = 2,
  parameter int GAP_CYCLES = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [23:0]       src_addr,
  input  logic [DEST_W-1:0] dst_addr,
  input  logic [LEN_W-1:0]  byte_len,
  output logic              busy,
  output logic              done,
  output logic              mem_we,
  output logic [DEST_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1);
  localparam int CHUNK_MAX = FIFO_DEPTH - HDR_BYTES;
  localparam int GAP_W     = $clog2(GAP_CYCLES + 1);

  seq_state_t        st;
  logic [23:0]       src_q;
  logic [DEST_W-1:0] dst_q;
  logic [LEN_W-1:0]  remain;
  logic [CNT_W-1:0]  cur_len;
  logic [CNT_W-1:0]  step;
  logic [GAP_W-1:0]  gap_cnt;
  logic              we_q;
  logic [DEST_W-1:0] waddr_q;
  logic [7:0]        wdata_q;

  // Named internal events for the checker.
  logic             ev_chunk_start;
  logic             ev_drop;
  logic             ev_store;
  logic             ev_last_store;
  logic             rx_ready;
  logic             fifo_pop;
  logic [7:0]       fifo_dout;
  logic [CNT_W-1:0] fifo_count;
  logic             rx_push;
  logic [7:0]       rx_byte;
  logic             burst_end;
  logic [CNT_W-1:0] burst_total;
  logic [LEN_W-1:0] remain_after;

  function automatic logic [CNT_W-1:0] len_of(input logic [LEN_W-1:0] r);
    return CNT_W'(chunk_take(32'(r), 32'(CHUNK_MAX)));
  endfunction

  assign ev_chunk_start = (st == SQ_LOAD);
  assign ev_drop        = (st == SQ_SKIP);
  assign ev_store       = (st == SQ_DRAIN);
  assign ev_last_store  = ev_store && (step == cur_len - 1'b1);
  assign fifo_pop       = ev_drop || ev_store;
  assign burst_total    = CNT_W'(HDR_BYTES) + cur_len;
  assign rx_ready       = (fifo_count >= burst_total);
  assign remain_after   = remain - LEN_W'(cur_len);

  assign busy      = (st != SQ_IDLE);
  assign done      = (st == SQ_FINISH);
  assign mem_we    = we_q;
  assign mem_addr  = waddr_q;
  assign mem_wdata = wdata_q;

  spi_burst_engine #(
    .HALF_DIV (HALF_DIV),
    .CNT_W    (CNT_W)
  ) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (ev_chunk_start),
    .total     (burst_total),
    .tx_cnt    (CNT_W'(HDR_BYTES)),
    .header    (read_header(src_q)),
    .sclk      (spi_sclk),
    .cs_n      (spi_cs_n),
    .mosi      (spi_mosi),
    .miso      (spi_miso),
    .rx_push   (rx_push),
    .rx_byte   (rx_byte),
    .burst_end (burst_end)
  );

  spi_rx_fifo #(
    .DEPTH (FIFO_DEPTH),
    .CNT_W (CNT_W)
  ) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_push),
    .din   (rx_byte),
    .pop   (fifo_pop),
    .dout  (fifo_dout),
    .count (fifo_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      remain  <= '0;
      cur_len <= '0;
      step    <= '0;
      gap_cnt <= '0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= 1'b0;
      if (burst_end)            gap_cnt <= GAP_W'(GAP_CYCLES);
      else if (gap_cnt != '0)   gap_cnt <= gap_cnt - 1'b1;

      unique case (st)
        SQ_IDLE: begin
          if (start) begin
            src_q   <= src_addr;
            dst_q   <= dst_addr;
            remain  <= byte_len;
            cur_len <= len_of(byte_len);
            st      <= (byte_len == '0) ? SQ_FINISH : SQ_LOAD;
          end
        end
        SQ_LOAD: st <= SQ_WAIT;
        SQ_WAIT: begin
          if (rx_ready) begin
            step <= '0;
            st   <= SQ_SKIP;
          end
        end
        SQ_SKIP: begin
          if (step == CNT_W'(HDR_BYTES - 1)) begin
            step <= '0;
            st   <= SQ_DRAIN;
          end else begin
            step <= step + 1'b1;
          end
        end
        SQ_DRAIN: begin
          we_q    <= 1'b1;
          waddr_q <= dst_q;
          wdata_q <= fifo_dout;
          dst_q   <= dst_q + 1'b1;
          if (ev_last_store) begin
            src_q   <= src_q + 24'(cur_len);
            remain  <= remain_after;
            cur_len <= len_of(remain_after);
            st      <= SQ_GAP;
          end else begin
            step <= step + 1'b1;
          end
        end
        SQ_GAP: begin
          if (gap_cnt == '0) st <= (remain == '0) ? SQ_FINISH : SQ_LOAD;
        end
        SQ_FINISH: st <= SQ_IDLE;
        default:   st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_chunk_reader_chk.sv
module spi_chunk_reader_chk #(
  parameter int DEST_W     = 16,
  parameter int LEN_W      = 16,
  parameter int CNT_W      = 7,
  parameter int FIFO_DEPTH = 64,
  parameter int GAP_CYCLES = 100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [LEN_W-1:0]  byte_len,
  input logic              busy,
  input logic              done,
  input logic              mem_we,
  input logic [DEST_W-1:0] mem_addr,
  input logic              spi_sclk,
  input logic              spi_cs_n,
  input logic              ev_chunk_start,
  input logic [CNT_W-1:0]  cur_len,
  input logic              fifo_push,
  input logic [CNT_W-1:0]  fifo_count
);

  localparam int CHUNK_MAX = FIFO_DEPTH - 4;
  localparam int HI_W      = $clog2(GAP_CYCLES + 2);

  logic [HI_W-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            hi_cnt <= HI_W'(GAP_CYCLES);
    else if (!spi_cs_n)                    hi_cnt <= '0;
    else if (hi_cnt < HI_W'(GAP_CYCLES))   hi_cnt <= hi_cnt + 1'b1;
  end

  AST_CHUNK_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_chunk_start |-> (cur_len != '0) && (cur_len <= CNT_W'(CHUNK_MAX))); // R2
  AST_FIFO_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> (fifo_count < CNT_W'(FIFO_DEPTH))); // R2
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R3
  AST_WR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == DEST_W'($past(mem_addr) + 1'b1))); // R4
  AST_DESELECT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (hi_cnt >= HI_W'(GAP_CYCLES))); // R6
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (byte_len == '0)) |=> done); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R8
  AST_NO_WR_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !mem_we); // R11

endmodule

bind spi_chunk_reader spi_chunk_reader_chk #(
  .DEST_W     (DEST_W),
  .LEN_W      (LEN_W),
  .CNT_W      (CNT_W),
  .FIFO_DEPTH (FIFO_DEPTH),
  .GAP_CYCLES (GAP_CYCLES)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start          (start),
  .byte_len       (byte_len),
  .busy           (busy),
  .done           (done),
  .mem_we         (mem_we),
  .mem_addr       (mem_addr),
  .spi_sclk       (spi_sclk),
  .spi_cs_n       (spi_cs_n),
  .ev_chunk_start (ev_chunk_start),
  .cur_len        (cur_len),
  .fifo_push      (rx_push),
  .fifo_count     (fifo_count)
);

// File: tb/spi_chunk_reader_test.sv
module spi_chunk_reader_test;

  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 100;
  localparam int CAP        = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] src_addr = '0;
  logic [15:0] dst_addr = '0;
  logic [15:0] byte_len = '0;
  logic        busy, done, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b1;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  spi_chunk_reader uut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr),
    .dst_addr(dst_addr), .byte_len(byte_len), .busy(busy), .done(done),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] flash_at(input logic [23:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ {a[22:16], a[23]} ^ 8'h5C;
  endfunction

  // Reference model state: expected writes, expected bursts.
  logic [15:0] exp_wa[$];
  logic [7:0]  exp_wd[$];
  logic [23:0] exp_ca[$];
  int          exp_cl[$];
  int          done_pending = 0;
  bit          prev_done = 1'b0;
  int          cs_falls = 0;
  int          wr_seen = 0;

  // Behavioural flash.
  bit          in_burst = 1'b0;
  bit          rise_seen = 1'b0;
  longint      rise_cyc = 0;
  int          fbit = 0;
  int          fbyte = 0;
  logic [7:0]  fin = '0;
  logic [7:0]  fout = 8'hA5;
  logic [7:0]  hdr [4];
  logic [23:0] faddr = '0;

  always @(negedge spi_cs_n) begin
    cs_falls++;
    if (rise_seen) chk(cyc - rise_cyc >= GAP, "R6", "deselect cycles", cyc - rise_cyc, GAP);
    in_burst = 1'b1;
    fbit = 0; fbyte = 0; fout = 8'hA5;
    spi_miso = fout[7];
  end

  always @(posedge spi_sclk) if (spi_cs_n === 1'b0) begin
    fin = {fin[6:0], spi_mosi};
    fbit++;
    if (fbit == 8) begin
      fbit = 0;
      if (fbyte < 4) hdr[fbyte] = fin;
      fbyte++;
      if (fbyte == 4) faddr = {hdr[1], hdr[2], hdr[3]};
      if (fbyte >= 4) begin
        fout = flash_at(faddr);
        faddr = faddr + 24'd1;
      end else begin
        fout = 8'hA5 ^ 8'(fbyte);
      end
    end
  end

  always @(negedge spi_sclk) if (spi_cs_n === 1'b0) spi_miso = fout[7 - fbit];

  always @(posedge spi_cs_n) if (in_burst) begin
    in_burst = 1'b0;
    rise_seen = 1'b1;
    rise_cyc = cyc;
    if (exp_ca.size() == 0) begin
      chk(1'b0, "R2", "unexpected burst", fbyte, 0);
    end else begin
      chk(hdr[0] == 8'h03, "R1", "opcode", hdr[0], 8'h03);
      chk({hdr[1], hdr[2], hdr[3]} == exp_ca[0], "R1", "burst address",
          {hdr[1], hdr[2], hdr[3]}, exp_ca[0]);
      chk(fbyte == 4 + exp_cl[0] && fbit == 0, "R3", "bytes per burst", fbyte, 4 + exp_cl[0]);
      chk(fbyte - 4 <= CAP, "R2", "payload cap", fbyte - 4, CAP);
      void'(exp_ca.pop_front());
      void'(exp_cl.pop_front());
    end
  end

  // Per-clock comparison against the reference model.
  always @(negedge clk) if (rst_n) begin
    if (mem_we) begin
      wr_seen++;
      if (exp_wa.size() == 0) begin
        chk(1'b0, "R4", "unexpected write", mem_addr, 0);
      end else begin
        chk(mem_addr == exp_wa[0], "R5", "write address", mem_addr, exp_wa[0]);
        chk(mem_wdata == exp_wd[0], "R4", "write data", mem_wdata, exp_wd[0]);
        void'(exp_wa.pop_front());
        void'(exp_wd.pop_front());
      end
      chk(spi_cs_n == 1'b1, "R11", "write while selected", spi_cs_n, 1);
    end
    if (done) begin
      chk(done_pending > 0, "R8", "done without request", done_pending, 1);
      chk(exp_wa.size() == 0, "R8", "writes left at done", exp_wa.size(), 0);
      chk(!prev_done, "R8", "done longer than one cycle", prev_done, 0);
      if (done_pending > 0) done_pending--;
    end
    prev_done = done;
  end

  task automatic copy(input logic [23:0] s, input logic [15:0] d, input int n,
                      input bit poke);
    int t;
    for (int off = 0; off < n; off += CAP) begin
      exp_ca.push_back(s + 24'(off));
      exp_cl.push_back((n - off > CAP) ? CAP : n - off);
    end
    for (int i = 0; i < n; i++) begin
      exp_wa.push_back(d + 16'(i));
      exp_wd.push_back(flash_at(s + 24'(i)));
    end
    done_pending++;
    @(negedge clk);
    src_addr = s; dst_addr = d; byte_len = 16'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0; src_addr = 24'hABCDEF; dst_addr = 16'hDEAD; byte_len = 16'd3;
    chk(busy == 1'b1, "R8", "busy after start", busy, 1);
    if (poke) begin
      repeat (300) @(negedge clk);
      src_addr = 24'h123456; dst_addr = 16'h7000; byte_len = 16'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R9", "busy kept after ignored start", busy, 1);
    end
    t = 0;
    while (done !== 1'b1 && t < 40000) begin
      @(negedge clk);
      t++;
    end
    chk(done === 1'b1, "R8", "done reached", done, 1);
    chk(exp_ca.size() == 0, "R5", "bursts left", exp_ca.size(), 0);
    chk(exp_wa.size() == 0, "R5", "writes left", exp_wa.size(), 0);
    @(negedge clk);
    chk(busy == 1'b0, "R8", "idle after done", busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int falls0, wr0;
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R10", "cs_n in reset", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R10", "sclk in reset", spi_sclk, 0);
    chk(mem_we == 1'b0, "R10", "mem_we in reset", mem_we, 0);
    chk(done == 1'b0, "R10", "done in reset", done, 0);
    chk(busy == 1'b0, "R10", "busy in reset", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7: zero length
    falls0 = cs_falls; wr0 = wr_seen;
    done_pending++;
    src_addr = 24'h000100; dst_addr = 16'h0010; byte_len = 16'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R7", "done one cycle after zero-length start", done, 1);
    repeat (20) @(negedge clk);
    chk(cs_falls == falls0, "R7", "no burst for zero length", cs_falls, falls0);
    chk(wr_seen == wr0, "R7", "no write for zero length", wr_seen, wr0);

    copy(24'h000040, 16'h0100, 1, 1'b0);     // single byte
    copy(24'h001000, 16'h0200, 60, 1'b0);    // exactly one full burst, R2
    copy(24'h002003, 16'h0300, 61, 1'b0);    // full plus remainder, R2
    // R9: start in the middle of a three-burst copy
    falls0 = cs_falls;
    copy(24'h030000, 16'h0400, 130, 1'b1);
    chk(cs_falls - falls0 == 3, "R9", "burst count with ignored start", cs_falls - falls0, 3);
    wr0 = wr_seen; falls0 = cs_falls;
    repeat (300) @(negedge clk);
    chk(wr_seen == wr0 && cs_falls == falls0, "R9", "no activity from ignored start",
        wr_seen - wr0, 0);
    // R6 across requests: back to back
    copy(24'h00FFE0, 16'h0800, 70, 1'b0);
    copy(24'hFFFFFE, 16'h0900, 5, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule